// File: doc/BRIEF.md
# Burst Memory Transfer Sequencer

This block moves data between an external memory and an internal compute path. It talks to the memory over two independent channels, one for reading and one for writing. A run begins with a start pulse. The block then issues one burst read request, takes the returned words, and finally writes a block of words back one at a time, each with its own address.

In compute mode the words read are a vector of N entries followed by an N×N matrix stored row by row. The block multiplies the matrix by the vector on the fly and writes back N results. In loopback mode a burst is copied into an internal buffer and written back unchanged, which makes it easy to check the external memory path.

The read and write base addresses are separate, so the two regions can differ. All configuration is sampled at the accepted start pulse.

Top module: `burst_xfer_ctrl`

## Requirements
- R1: While reset is asserted (rstN low) and after it is released, busy, done, rdReqValid and wrValid are all 0.
- R2: A start pulse is accepted only while the block is idle, and never in the single cycle that follows completion. An accepted start latches mode, size, burst length and both base addresses. Start pulses and configuration changes at other times have no effect on the run in progress.
- R3: After an accepted start with a nonzero transfer count, rdReqValid is held high until the first cycle in which rdReqAck is high, and then drops for the rest of the run. While it is high, rdReqAddr equals the latched read base and rdReqLen equals N+N·N in compute mode or the burst length in loopback mode.
- R4: The read phase ends on the rdDataValid that brings in the rdReqLen-th word. A data word may arrive in the same cycle as rdReqAck. wrValid rises two clock edges after that final word.
- R5: In loopback mode (cfgCompute=0), write k (k = 0 … L-1) carries address writeBase+k and the k-th word that was read.
- R6: In compute mode (cfgCompute=1), the first N read words are vector v and the next N·N are matrix a in row-major order. Write r (r = 0 … N-1) carries address writeBase+r and the value Σc a[r][c]·v[c], unsigned, modulo 2^DATA_W.
- R7: While wrValid is high, wrAddr and wrData stay stable until wrAck. Each wrAck retires exactly one word.
- R8: busy is high from the edge that accepts a start until the edge that takes the last wrAck. At that edge done rises, and it stays high until the next accepted start. busy and done are never high together.
- R9: If the transfer count is zero (N in compute mode, the burst length in loopback mode), done is high one edge after the start. busy never rises, and neither rdReqValid nor wrValid is asserted.
- R10: A size above MAX_N is treated as MAX_N, and a burst length above BUF_DEPTH is treated as BUF_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgCompute | input | 1 | 1 = compute mode, 0 = loopback mode |
| cfgSize | input | $clog2(MAX_N+1) | Matrix dimension N |
| cfgBurstLen | input | $clog2(BUF_DEPTH+1) | Loopback word count |
| cfgRdBase | input | ADDR_W | Read region base address |
| cfgWrBase | input | ADDR_W | Write region base address |
| startPulse | input | 1 | Start request |
| rdReqValid | output | 1 | Read burst request |
| rdReqAck | input | 1 | Read request accepted |
| rdReqAddr | output | ADDR_W | Read burst start address |
| rdReqLen | output | RL_W | Read burst word count |
| rdDataValid | input | 1 | Read word strobe |
| rdData | input | DATA_W | Read word |
| wrValid | output | 1 | Write word request |
| wrAck | input | 1 | Write word accepted |
| wrAddr | output | ADDR_W | Write word address |
| wrData | output | DATA_W | Write word data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |

## Verification
Three coincidences are provoked on purpose. First, rdReqAck and the first rdDataValid can land in the same cycle. Second, a start pulse can land in the same cycle as the final wrAck. Third, a start pulse can arrive in the single cycle after completion. The bench forces these by running a memory responder with zero latency and by raising start on every cycle of a run. A behavioural reference model, updated on each edge, decides whether each such start was accepted and whether each early word was counted. The model is compared with busy, done and both channels on every clock.

// File: rtl/bxc_pkg.sv
package bxc_pkg;
  typedef enum logic [2:0] {S_IDLE, S_READ, S_WAIT, S_WRITE, S_DONE} bxcState_t;

  typedef struct packed {
    logic clear;    // new run accepted
    logic take;     // read word arrives this cycle
    logic compute;  // latched mode
  } dpCtl_t;
endpackage

// File: rtl/bxc_ctrl.sv
module bxc_ctrl
  import bxc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_N     = 8,
  parameter int BUF_DEPTH = 64,
  parameter int SZ_W      = 4,
  parameter int BL_W      = 7,
  parameter int RL_W      = 7,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCompute,
  input  logic [SZ_W-1:0]   cfgSize,
  input  logic [BL_W-1:0]   cfgBurstLen,
  input  logic [ADDR_W-1:0] cfgRdBase,
  input  logic [ADDR_W-1:0] cfgWrBase,
  input  logic              startPulse,
  output logic              rdReqValid,
  input  logic              rdReqAck,
  output logic [ADDR_W-1:0] rdReqAddr,
  output logic [RL_W-1:0]   rdReqLen,
  input  logic              rdDataValid,
  output logic              wrValid,
  input  logic              wrAck,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [SZ_W-1:0]   nOut,
  output dpCtl_t            dpCtl,
  output logic              busy,
  output logic              done
);
  bxcState_t         state;
  logic              modeQ, reqDone;
  logic [SZ_W-1:0]   nQ;
  logic [ADDR_W-1:0] rdBaseQ, wrBaseQ;
  logic [RL_W-1:0]   rdLenQ, rdCnt;
  logic [BL_W-1:0]   wrLenQ, wrCnt;

  logic [SZ_W-1:0] nEff;
  logic [BL_W-1:0] blEff, wrLenNew;
  logic [RL_W-1:0] rdLenNew;
  logic accept, zeroLen, rdLast, wrLast;

  always_comb begin
    nEff     = (cfgSize > SZ_W'(MAX_N)) ? SZ_W'(MAX_N) : cfgSize;
    blEff    = (cfgBurstLen > BL_W'(BUF_DEPTH)) ? BL_W'(BUF_DEPTH) : cfgBurstLen;
    rdLenNew = cfgCompute ? (RL_W'(nEff) + RL_W'(nEff) * RL_W'(nEff)) : RL_W'(blEff);
    wrLenNew = cfgCompute ? BL_W'(nEff) : blEff;
    accept   = (state == S_IDLE) && startPulse;
    zeroLen  = (wrLenNew == '0);
    rdLast   = (state == S_READ) && rdDataValid && (rdCnt == rdLenQ - RL_W'(1));
    wrLast   = (state == S_WRITE) && wrAck && (wrCnt == wrLenQ - BL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      modeQ   <= 1'b0;
      nQ      <= '0;
      rdBaseQ <= '0;
      wrBaseQ <= '0;
      rdLenQ  <= '0;
      wrLenQ  <= '0;
      rdCnt   <= '0;
      wrCnt   <= '0;
      reqDone <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          modeQ   <= cfgCompute;
          nQ      <= nEff;
          rdBaseQ <= cfgRdBase;
          wrBaseQ <= cfgWrBase;
          rdLenQ  <= rdLenNew;
          wrLenQ  <= wrLenNew;
          rdCnt   <= '0;
          wrCnt   <= '0;
          reqDone <= 1'b0;
          if (zeroLen) begin
            state <= S_DONE;
            done  <= 1'b1;
          end else begin
            state <= S_READ;
            busy  <= 1'b1;
            done  <= 1'b0;
          end
        end
        S_READ: begin
          if (rdReqValid && rdReqAck) reqDone <= 1'b1;
          if (rdDataValid) rdCnt <= rdCnt + RL_W'(1);
          if (rdLast) state <= S_WAIT;
        end
        S_WAIT: begin
          wrCnt <= '0;
          state <= S_WRITE;
        end
        S_WRITE: if (wrAck) begin
          if (wrLast) begin
            state <= S_DONE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else begin
            wrCnt <= wrCnt + BL_W'(1);
          end
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rdReqValid    = (state == S_READ) && !reqDone;
    rdReqAddr     = rdBaseQ;
    rdReqLen      = rdLenQ;
    wrValid       = (state == S_WRITE);
    wrAddr        = wrBaseQ + ADDR_W'(wrCnt);
    wrIdx         = IDX_W'(wrCnt);
    nOut          = nQ;
    dpCtl.clear   = accept;
    dpCtl.take    = (state == S_READ) && rdDataValid;
    dpCtl.compute = modeQ;
  end

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R3
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqAck) |=> (rdReqValid && $stable(rdReqAddr) && $stable(rdReqLen)));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrAck) |=> (wrValid && $stable(wrAddr)));

  // R2
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && startPulse) |=> ($stable(rdBaseQ) && $stable(wrBaseQ) && $stable(modeQ)));

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && zeroLen) |=> (done && !busy && !rdReqValid));

  // R4
  rd_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && rdDataValid) |-> (reqDone || rdReqAck));
endmodule

// File: rtl/bxc_dpath.sv
module bxc_dpath
  import bxc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_N     = 8,
  parameter int BUF_DEPTH = 64,
  parameter int SZ_W      = 4,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [SZ_W-1:0]   nQ,
  input  logic [DATA_W-1:0] rdData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] wrData
);
  localparam int VIDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  logic [DATA_W-1:0] vecMem [MAX_N];
  logic [DATA_W-1:0] bufMem [BUF_DEPTH];
  logic [IDX_W-1:0]  fillCnt;
  logic [SZ_W-1:0]   col, row;
  logic [DATA_W-1:0] acc, macSum;
  logic              inMatrix;
  logic              vecLast, rowLast;

  always_comb begin
    macSum  = acc + DATA_W'(rdData * vecMem[col[VIDX_W-1:0]]);
    vecLast = (fillCnt == IDX_W'(nQ) - IDX_W'(1));
    rowLast = (col == nQ - SZ_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      col      <= '0;
      row      <= '0;
      acc      <= '0;
      inMatrix <= 1'b0;
    end else if (ctl.clear) begin
      fillCnt  <= '0;
      col      <= '0;
      row      <= '0;
      acc      <= '0;
      inMatrix <= 1'b0;
    end else if (ctl.take) begin
      if (!ctl.compute || !inMatrix) begin
        fillCnt <= fillCnt + IDX_W'(1);
        if (ctl.compute && vecLast) inMatrix <= 1'b1;
      end else if (rowLast) begin
        acc <= '0;
        col <= '0;
        row <= row + SZ_W'(1);
      end else begin
        acc <= macSum;
        col <= col + SZ_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.take) begin
      if (!ctl.compute) bufMem[fillCnt] <= rdData;
      else if (!inMatrix) vecMem[fillCnt[VIDX_W-1:0]] <= rdData;
      else if (rowLast) bufMem[IDX_W'(row)] <= macSum;
    end
  end

  assign wrData = bufMem[rdIdx];

  // R6
  mac_col_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.take && ctl.compute && inMatrix) |-> (col < nQ && row < nQ));
endmodule

// File: rtl/burst_xfer_ctrl.sv
module burst_xfer_ctrl
  import bxc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 32,
  parameter int MAX_N     = 8,
  parameter int BUF_DEPTH = 64,
  localparam int SZ_W     = $clog2(MAX_N + 1),
  localparam int BL_W     = $clog2(BUF_DEPTH + 1),
  localparam int RD_MAX   = (MAX_N + MAX_N * MAX_N > BUF_DEPTH) ? (MAX_N + MAX_N * MAX_N) : BUF_DEPTH,
  localparam int RL_W     = $clog2(RD_MAX + 1),
  localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgCompute,
  input  logic [SZ_W-1:0]   cfgSize,
  input  logic [BL_W-1:0]   cfgBurstLen,
  input  logic [ADDR_W-1:0] cfgRdBase,
  input  logic [ADDR_W-1:0] cfgWrBase,
  input  logic              startPulse,
  output logic              rdReqValid,
  input  logic              rdReqAck,
  output logic [ADDR_W-1:0] rdReqAddr,
  output logic [RL_W-1:0]   rdReqLen,
  input  logic              rdDataValid,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrValid,
  input  logic              wrAck,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done
);
  dpCtl_t           dpCtl;
  logic [IDX_W-1:0] wrIdx;
  logic [SZ_W-1:0]  nLat;

  bxc_ctrl #(
    .ADDR_W(ADDR_W), .MAX_N(MAX_N), .BUF_DEPTH(BUF_DEPTH),
    .SZ_W(SZ_W), .BL_W(BL_W), .RL_W(RL_W), .IDX_W(IDX_W)
  ) ctrlU (
    .clk(clk), .rstN(rstN),
    .cfgCompute(cfgCompute), .cfgSize(cfgSize), .cfgBurstLen(cfgBurstLen),
    .cfgRdBase(cfgRdBase), .cfgWrBase(cfgWrBase), .startPulse(startPulse),
    .rdReqValid(rdReqValid), .rdReqAck(rdReqAck), .rdReqAddr(rdReqAddr),
    .rdReqLen(rdReqLen), .rdDataValid(rdDataValid),
    .wrValid(wrValid), .wrAck(wrAck), .wrAddr(wrAddr), .wrIdx(wrIdx),
    .nOut(nLat), .dpCtl(dpCtl), .busy(busy), .done(done)
  );

  bxc_dpath #(
    .DATA_W(DATA_W), .MAX_N(MAX_N), .BUF_DEPTH(BUF_DEPTH),
    .SZ_W(SZ_W), .IDX_W(IDX_W)
  ) dpathU (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .nQ(nLat),
    .rdData(rdData), .rdIdx(wrIdx), .wrData(wrData)
  );
endmodule

// File: tb/tb_burst_xfer_ctrl.sv
module tb_burst_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 8;
  localparam int DEPTH = 64;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgCompute = 1'b0;
  logic [3:0]  cfgSize = '0;
  logic [6:0]  cfgBurstLen = '0;
  logic [31:0] cfgRdBase = '0, cfgWrBase = '0;
  logic        startPulse = 1'b0;
  logic        rdReqValid, rdReqAck = 1'b0;
  logic [31:0] rdReqAddr;
  logic [6:0]  rdReqLen;
  logic        rdDataValid = 1'b0;
  logic [15:0] rdData = '0;
  logic        wrValid, wrAck = 1'b0;
  logic [31:0] wrAddr;
  logic [15:0] wrData;
  logic        busy, done;

  burst_xfer_ctrl dut (
    .clk(clk), .rstN(rstN), .cfgCompute(cfgCompute), .cfgSize(cfgSize),
    .cfgBurstLen(cfgBurstLen), .cfgRdBase(cfgRdBase), .cfgWrBase(cfgWrBase),
    .startPulse(startPulse), .rdReqValid(rdReqValid), .rdReqAck(rdReqAck),
    .rdReqAddr(rdReqAddr), .rdReqLen(rdReqLen), .rdDataValid(rdDataValid),
    .rdData(rdData), .wrValid(wrValid), .wrAck(wrAck), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  longint rmem [0:1023];
  longint expW [0:127];
  logic [31:0] seed = 32'h1234_5678;
  int pol = 0, stray = 0, startReq = 0;
  int obsWrites = 0, obsReq = 0;

  // reference model state: 0 idle, 1 read, 2 wait, 3 write, 4 done
  int mState = 0, mBusy = 0, mDone = 0, mMode = 0, mReqDone = 0;
  int mRdLen = 0, mWrLen = 0, mRdCnt = 0, mWrCnt = 0;
  longint mRdBase = 0, mWrBase = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic step();
    int mRdV;
    int n, bl;
    mRdV = (mState == 1 && mReqDone == 0) ? 1 : 0;
    // compare outputs against the model
    check("R8 busy", longint'(busy), mBusy);
    check("R8 done", longint'(done), mDone);
    check("R3 rdReqValid", longint'(rdReqValid), mRdV);
    if (mRdV != 0) begin
      check("R3 rdReqAddr", longint'(rdReqAddr), mRdBase);
      check("R3 rdReqLen", longint'(rdReqLen), mRdLen);
    end
    check("R4 wrValid", longint'(wrValid), (mState == 3) ? 1 : 0);
    if (mState == 3) begin
      check("R7 wrAddr", longint'(wrAddr), mWrBase + mWrCnt);
      if (mMode != 0) check("R6 wrData", longint'(wrData), expW[mWrCnt]);
      else            check("R5 wrData", longint'(wrData), expW[mWrCnt]);
    end
    if (rdReqValid) obsReq++;
    // drive inputs for the next edge
    seed = seed * 32'd1664525 + 32'd1013904223;
    rdReqAck    = (mRdV != 0) && (pol == 0 || seed[20]);
    rdDataValid = (mState == 1) && (mReqDone != 0 || rdReqAck) && (pol == 0 || seed[25:24] != 2'b00);
    rdData      = 16'(rmem[(mRdBase + mRdCnt) % 1024]);
    wrAck       = (mState == 3) && (pol == 0 || seed[27]);
    startPulse  = 1'b0;
    if (startReq != 0) startPulse = 1'b1;
    else if (mState != 0 && (stray == 2 || (stray == 1 && seed[22]))) begin
      startPulse  = 1'b1;
      cfgCompute  = seed[9];
      cfgSize     = seed[13:10];
      cfgBurstLen = seed[19:13];
      cfgRdBase   = {24'd0, seed[31:24]};
      cfgWrBase   = {24'd0, seed[30:23]};
    end
    if (wrAck) obsWrites++;
    // advance the model to match the coming edge
    case (mState)
      0: if (startPulse) begin
        n  = (int'(cfgSize) > MAXN) ? MAXN : int'(cfgSize);
        bl = (int'(cfgBurstLen) > DEPTH) ? DEPTH : int'(cfgBurstLen);
        mMode = int'(cfgCompute);
        mRdBase = longint'(cfgRdBase);
        mWrBase = longint'(cfgWrBase);
        mRdLen = (mMode != 0) ? n + n * n : bl;
        mWrLen = (mMode != 0) ? n : bl;
        if (mMode != 0) begin
          for (int r = 0; r < n; r++) begin
            longint s = 0;
            for (int c = 0; c < n; c++)
              s = (s + rmem[(mRdBase + n + r * n + c) % 1024] * rmem[(mRdBase + c) % 1024]) & 64'hFFFF;
            expW[r] = s;
          end
        end else begin
          for (int k = 0; k < bl; k++) expW[k] = rmem[(mRdBase + k) % 1024];
        end
        if (mWrLen == 0) begin
          mState = 4; mDone = 1;
        end else begin
          mState = 1; mBusy = 1; mDone = 0; mReqDone = 0; mRdCnt = 0;
        end
      end
      1: begin
        if (rdReqAck) mReqDone = 1;
        if (rdDataValid) begin
          mRdCnt++;
          if (mRdCnt == mRdLen) mState = 2;
        end
      end
      2: begin mState = 3; mWrCnt = 0; end
      3: if (wrAck) begin
        if (mWrCnt == mWrLen - 1) begin mState = 4; mBusy = 0; mDone = 1; end
        else mWrCnt++;
      end
      default: mState = 0;
    endcase
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      finishRun();
    end
  endtask

  task automatic runOp(int mode, int size, int blen, int rdb, int wrb, int p, int s);
    cfgCompute  = mode[0];
    cfgSize     = 4'(size);
    cfgBurstLen = 7'(blen);
    cfgRdBase   = 32'(rdb);
    cfgWrBase   = 32'(wrb);
    pol = p; stray = s;
    obsWrites = 0; obsReq = 0;
    startReq = 1;
    step();
    startReq = 0;
    while (mState != 0) step();
    stray = 0;
    step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) rmem[i] = (longint'(i) * 40503 + 977) & 64'hFFFF;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R1 busy in reset", longint'(busy), 0);
      check("R1 done in reset", longint'(done), 0);
      check("R1 rdReqValid in reset", longint'(rdReqValid), 0);
      check("R1 wrValid in reset", longint'(wrValid), 0);
      @(negedge clk);
    end
    rstN = 1'b1;
    step();
    step();

    // loopback, zero-latency memory: ack and first word in one cycle
    runOp(0, 0, 5, 16, 300, 0, 0);
    check("R5 loopback write count", obsWrites, 5);
    // loopback with random gaps and stray starts mid-run
    runOp(0, 3, 12, 40, 500, 1, 1);
    check("R2 stray starts ignored, write count", obsWrites, 12);
    check("R3 single request cycle count", obsReq >= 1 ? 1 : 0, 1);
    // compute mode, several sizes
    runOp(1, 3, 9, 100, 700, 1, 0);
    check("R6 compute write count N=3", obsWrites, 3);
    runOp(1, 1, 0, 200, 710, 0, 0);
    check("R6 compute write count N=1", obsWrites, 1);
    runOp(1, 8, 0, 250, 720, 1, 2);
    check("R6 compute write count N=8 with starts every cycle", obsWrites, 8);
    // clamping
    runOp(1, 12, 0, 330, 800, 0, 0);
    check("R10 size clamp write count", obsWrites, MAXN);
    runOp(0, 0, 70, 420, 900, 1, 0);
    check("R10 burst clamp write count", obsWrites, DEPTH);
    // zero transfer count in both modes
    runOp(0, 5, 0, 10, 20, 0, 0);
    check("R9 zero burst no request", obsReq, 0);
    check("R9 zero burst no write", obsWrites, 0);
    check("R9 zero burst done", longint'(done), 1);
    runOp(1, 0, 9, 10, 20, 0, 0);
    check("R9 zero size no request", obsReq, 0);
    check("R9 zero size done", longint'(done), 1);
    // start landing in the cycle after completion is ignored
    cfgCompute = 1'b0; cfgBurstLen = 7'd4; cfgRdBase = 32'd60; cfgWrBase = 32'd61;
    pol = 0; obsWrites = 0;
    startReq = 1; step(); startReq = 0;
    while (mState != 4) step();
    startReq = 1; step(); startReq = 0;
    check("R2 start in completion cycle ignored, busy", longint'(busy), 0);
    check("R8 done held", longint'(done), 1);
    step(); step();
    check("R8 done still held when idle", longint'(done), 1);
    runOp(0, 0, 2, 70, 80, 0, 0);
    check("R5 follow-up run writes", obsWrites, 2);
    step();
    finishRun();
  end
endmodule